// File: doc/BRIEF.md
# Always-On Ring Write-Index Shadow File

This block sits in a power domain that never switches off and gives the host a place to post copy-engine ring write indices at any time, including while the copy-engine subsystem itself is powered down. It holds 24 write-only shadow entries. Each entry stands for one ring write index: either the source ring or the destination ring of one of twelve channels.

A host write always lands in the shadow storage and marks that entry as pending. Nothing is sent to the subsystem while its power-good input is low. Once the input is high, the pending entries are sent one at a time through a target-side register write port, lowest entry number first. Each transfer is held until the subsystem acknowledges it. An entry stays pending until its own transfer is acknowledged. If the host writes an entry again before it has been sent, only the newest value is sent. If the host writes an entry again while it is in flight, the entry is sent once more.

Top module: `ring_widx_shadow`

## Requirements
- R1: Entry n is written at byte address BASE_ADDR + 4*n, for n from 0 to 23. Entries 0 to 11 forward with `tgt_wr_dst`=0 (source ring) and `tgt_wr_chan`=n. Entries 12 to 23 forward with `tgt_wr_dst`=1 (destination ring) and `tgt_wr_chan`=n-12.
- R2: Only bits 15:0 of the host write data are forwarded on `tgt_wr_data`. Bits 31:16 are ignored.
- R3: A valid host write is accepted whatever the state of `subsys_up`. While `subsys_up` is low, `tgt_wr_valid` never rises. A value held during power-down is forwarded once `subsys_up` is high.
- R4: Several writes to one entry before it is forwarded produce a single transfer, which carries the last value written.
- R5: Pending entries are forwarded one at a time in ascending entry order. While a transfer waits for `tgt_wr_ack` with power up, `tgt_wr_valid`, `tgt_wr_dst`, `tgt_wr_chan` and `tgt_wr_data` hold steady. In the cycle after an acknowledge, `tgt_wr_valid` is low.
- R6: A pending flag clears only on acknowledge. An entry written again while its transfer is in flight is sent again with the newer value. A lower entry that becomes pending during replay is sent before any higher pending entry.
- R7: If `subsys_up` falls during a transfer, `tgt_wr_valid` is low after the next clock edge. That entry stays pending and is sent after power returns.
- R8: A write is ignored and sets `addr_err` if it falls below BASE_ADDR, at or beyond BASE_ADDR + 96, or off a 4-byte boundary. It causes no transfer. `addr_err` stays set until reset.
- R9: After reset, `tgt_wr_valid` and `addr_err` are low and no entry is pending, so raising `subsys_up` alone causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_wr_addr | input | 32 | Host byte address |
| host_wr_data | input | 32 | Host write data; the low 16 bits are used |
| subsys_up | input | 1 | High while the copy-engine subsystem is powered and clocked |
| tgt_wr_valid | output | 1 | Target-side write request |
| tgt_wr_dst | output | 1 | 0 = source-ring index, 1 = destination-ring index |
| tgt_wr_chan | output | 4 | Channel number 0 to 11 |
| tgt_wr_data | output | 16 | Write-index value |
| tgt_wr_ack | input | 1 | Subsystem accepts the pending request at this edge |
| addr_err | output | 1 | Sticky flag for an out-of-window or misaligned host write |

## Verification
A corrupted pending vector shows at the target port as a missing, duplicated or out-of-order transfer. This is visible within a few cycles of power-up, or of the acknowledge that ends the transfer before it. A stale or wrongly indexed value-store word shows up as a wrong `tgt_wr_data` on the very transfer that reads it. A wrong re-send decision during an in-flight rewrite shows up as a missing second transfer, or an extra one, right after the acknowledge. A bad decode shows as a wrong channel or ring kind, or as `addr_err` changing on the cycle after the offending write.

// File: rtl/shdw_pkg.sv
package shdw_pkg;
  // replay sequencer phases
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,  // choose lowest pending entry, start the store read
    SQ_LOAD = 2'd1,  // store read data arrives
    SQ_SEND = 2'd2   // request held on the target port until acknowledged
  } sq_state_t;
endpackage

// File: rtl/shdw_decode.sv
module shdw_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0003_2000,
  parameter int REGS = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             err_q
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(REGS * 4);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  always_comb begin
    off     = wr_addr - BASE_ADDR;
    in_win  = (wr_addr >= BASE_ADDR) && (off < SPAN) && (off[1:0] == 2'b00);
    hit     = wr_en && in_win;
    hit_idx = off[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else if (wr_en && !in_win)
      err_q <= 1'b1;
  end
endmodule

// File: rtl/shdw_store.sv
module shdw_store #(
  parameter int REGS = 24,
  parameter int IDX_W = 5,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [REGS-1:0]  pend
);
  // value store: one write port, one registered read port, no reset
  logic [VAL_W-1:0] mem [REGS];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_idx] <= wr_val;
    rd_val <= mem[rd_idx];
  end

  // pending flags: a new write wins over a clear in the same cycle
  genvar g;
  generate
    for (g = 0; g < REGS; g++) begin : g_pend
      always_ff @(posedge clk) begin
        if (rst)
          pend[g] <= 1'b0;
        else if (wr_en && wr_idx == IDX_W'(g))
          pend[g] <= 1'b1;
        else if (clr_en && clr_idx == IDX_W'(g))
          pend[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/shdw_replay.sv
module shdw_replay
  import shdw_pkg::*;
#(
  parameter int REGS = 24,
  parameter int CHANNELS = 12,
  parameter int IDX_W = 5,
  parameter int CH_W = 4,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_up,
  input  logic [REGS-1:0]  pend,
  input  logic             host_hit,
  input  logic [IDX_W-1:0] host_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [VAL_W-1:0] rd_val,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             tgt_valid,
  output logic             tgt_dst,
  output logic [CH_W-1:0]  tgt_chan,
  output logic [VAL_W-1:0] tgt_data,
  input  logic             tgt_ack
);
  sq_state_t        state;
  logic [IDX_W-1:0] cur_idx;
  logic             redo_q;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             hit_cur;
  logic             hit_pick;
  logic [IDX_W-1:0] dst_rel;

  // lowest pending entry wins
  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = REGS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hit_cur  = host_hit && (host_idx == cur_idx);
    hit_pick = host_hit && (host_idx == pick_idx);
    rd_idx   = (state == SQ_IDLE) ? pick_idx : cur_idx;
    clr_idx  = cur_idx;
    clr_en   = (state == SQ_SEND) && tgt_valid && tgt_ack && pwr_up && !(redo_q || hit_cur);
    dst_rel  = cur_idx - IDX_W'(CHANNELS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_idx   <= '0;
      redo_q    <= 1'b0;
      tgt_valid <= 1'b0;
      tgt_dst   <= 1'b0;
      tgt_chan  <= '0;
      tgt_data  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (pwr_up && pick_any) begin
            cur_idx <= pick_idx;
            redo_q  <= hit_pick;
            state   <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          redo_q <= redo_q | hit_cur;
          if (!pwr_up) begin
            state <= SQ_IDLE;
          end else begin
            tgt_valid <= 1'b1;
            tgt_data  <= rd_val;
            if (cur_idx >= IDX_W'(CHANNELS)) begin
              tgt_dst  <= 1'b1;
              tgt_chan <= dst_rel[CH_W-1:0];
            end else begin
              tgt_dst  <= 1'b0;
              tgt_chan <= cur_idx[CH_W-1:0];
            end
            state <= SQ_SEND;
          end
        end
        SQ_SEND: begin
          redo_q <= redo_q | hit_cur;
          if (!pwr_up || tgt_ack) begin
            tgt_valid <= 1'b0;
            state     <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_widx_shadow.sv
module ring_widx_shadow #(
  parameter int CHANNELS = 12,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VAL_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0003_2000,
  localparam int REGS = 2 * CHANNELS,
  localparam int IDX_W = $clog2(REGS),
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              subsys_up,
  output logic              tgt_wr_valid,
  output logic              tgt_wr_dst,
  output logic [CH_W-1:0]   tgt_wr_chan,
  output logic [VAL_W-1:0]  tgt_wr_data,
  input  logic              tgt_wr_ack,
  output logic              addr_err
);
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [VAL_W-1:0] rd_val;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic [REGS-1:0]  pend;
  logic             unused_hi;

  assign unused_hi = ^host_wr_data[DATA_W-1:VAL_W];

  shdw_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REGS(REGS), .IDX_W(IDX_W)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .wr_addr(host_wr_addr),
    .hit(hit), .hit_idx(hit_idx), .err_q(addr_err)
  );

  shdw_store #(
    .REGS(REGS), .IDX_W(IDX_W), .VAL_W(VAL_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(hit), .wr_idx(hit_idx),
    .wr_val(host_wr_data[VAL_W-1:0]), .rd_idx(rd_idx), .rd_val(rd_val),
    .clr_en(clr_en), .clr_idx(clr_idx), .pend(pend)
  );

  shdw_replay #(
    .REGS(REGS), .CHANNELS(CHANNELS), .IDX_W(IDX_W), .CH_W(CH_W), .VAL_W(VAL_W)
  ) u_replay (
    .clk(clk), .rst(rst), .pwr_up(subsys_up), .pend(pend),
    .host_hit(hit), .host_idx(hit_idx), .rd_idx(rd_idx), .rd_val(rd_val),
    .clr_en(clr_en), .clr_idx(clr_idx), .tgt_valid(tgt_wr_valid),
    .tgt_dst(tgt_wr_dst), .tgt_chan(tgt_wr_chan), .tgt_data(tgt_wr_data),
    .tgt_ack(tgt_wr_ack)
  );
endmodule

// File: rtl/shdw_chk.sv
module shdw_chk #(
  parameter int CHANNELS = 12,
  parameter int CH_W = 4,
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             subsys_up,
  input logic             tgt_wr_valid,
  input logic             tgt_wr_dst,
  input logic [CH_W-1:0]  tgt_wr_chan,
  input logic [VAL_W-1:0] tgt_wr_data,
  input logic             tgt_wr_ack,
  input logic             addr_err
);
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!tgt_wr_valid && !addr_err));

  // R1
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_wr_valid |-> (tgt_wr_chan < CH_W'(CHANNELS)));

  // R3
  start_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_wr_valid) |-> $past(subsys_up));

  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr_valid && !tgt_wr_ack && subsys_up) |=>
      (tgt_wr_valid && $stable(tgt_wr_data) && $stable(tgt_wr_chan) && $stable(tgt_wr_dst)));

  // R5
  one_per_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr_valid && tgt_wr_ack) |=> !tgt_wr_valid);

  // R7
  power_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !subsys_up |=> !tgt_wr_valid);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> addr_err);
endmodule

bind ring_widx_shadow shdw_chk #(
  .CHANNELS(CHANNELS), .CH_W(CH_W), .VAL_W(VAL_W)
) u_chk (
  .clk(clk), .rst(rst), .subsys_up(subsys_up), .tgt_wr_valid(tgt_wr_valid),
  .tgt_wr_dst(tgt_wr_dst), .tgt_wr_chan(tgt_wr_chan), .tgt_wr_data(tgt_wr_data),
  .tgt_wr_ack(tgt_wr_ack), .addr_err(addr_err)
);

// File: tb/ring_widx_shadow_bench.sv
`timescale 1ns/1ps
module ring_widx_shadow_bench;
  localparam logic [31:0] BASE = 32'h0003_2000;

  typedef struct packed {
    logic        dst;
    logic [3:0]  chan;
    logic [15:0] data;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_addr = '0;
  logic [31:0] host_wr_data = '0;
  logic        subsys_up = 1'b0;
  logic        tgt_wr_valid;
  logic        tgt_wr_dst;
  logic [3:0]  tgt_wr_chan;
  logic [15:0] tgt_wr_data;
  logic        tgt_wr_ack = 1'b0;
  logic        addr_err;

  int checks = 0;
  int errors = 0;
  int xfer_cnt = 0;
  int ack_delay = 0;
  int wcnt = 0;
  xfer_t exp_q[$];
  logic [15:0] m_val [24];
  logic        m_pend [24];

  always #2 clk = ~clk;

  ring_widx_shadow u_ring_widx_shadow (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .subsys_up(subsys_up), .tgt_wr_valid(tgt_wr_valid),
    .tgt_wr_dst(tgt_wr_dst), .tgt_wr_chan(tgt_wr_chan), .tgt_wr_data(tgt_wr_data),
    .tgt_wr_ack(tgt_wr_ack), .addr_err(addr_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic xfer_t mk(input int idx, input logic [15:0] v);
    xfer_t x;
    x.dst  = (idx >= 12);
    x.chan = (idx >= 12) ? 4'(idx - 12) : 4'(idx);
    x.data = v;
    return x;
  endfunction

  // driver: one host write, model updated per R1/R2/R4/R8
  task automatic host_write(input logic [31:0] addr, input logic [31:0] data);
    logic [31:0] off;
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_addr = addr;
    host_wr_data = data;
    off = addr - BASE;
    if (addr >= BASE && off < 32'd96 && off[1:0] == 2'b00) begin
      m_val[off[6:2]]  = data[15:0];
      m_pend[off[6:2]] = 1'b1;
    end
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  // scoreboard push: pending model entries in ascending order (R5)
  task automatic expect_replay();
    for (int i = 0; i < 24; i++) begin
      if (m_pend[i]) begin
        exp_q.push_back(mk(i, m_val[i]));
        m_pend[i] = 1'b0;
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || tgt_wr_valid) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // target responder and monitor
  always @(negedge clk) begin
    if (rst) begin
      tgt_wr_ack = 1'b0;
      wcnt = 0;
    end else if (tgt_wr_ack) begin
      tgt_wr_ack = 1'b0;
      wcnt = 0;
    end else if (!tgt_wr_valid) begin
      wcnt = 0;
    end else if (wcnt >= ack_delay) begin
      xfer_t got;
      xfer_t want;
      got = {tgt_wr_dst, tgt_wr_chan, tgt_wr_data};
      xfer_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected transfer", 32'(got), 32'h0);
      end else begin
        want = exp_q.pop_front();
        chk(got == want, "R1/R5", "transfer {dst,chan,data}", 32'(got), 32'(want));
      end
      tgt_wr_ack = 1'b1;
    end else begin
      wcnt++;
    end
  end

  initial begin
    #400000;
    chk(1'b0, "R5", "watchdog expired", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base_cnt;
    for (int i = 0; i < 24; i++) begin m_val[i] = '0; m_pend[i] = 1'b0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!tgt_wr_valid, "R9", "valid after reset", 32'(tgt_wr_valid), 32'h0);
    chk(!addr_err, "R9", "addr_err after reset", 32'(addr_err), 32'h0);
    subsys_up = 1'b1;
    repeat (20) @(negedge clk);
    chk(xfer_cnt == 0, "R9", "transfers with nothing pending", 32'(xfer_cnt), 32'h0);
    subsys_up = 1'b0;

    // R1 R2 R3: held while down, mapping and truncation after power-up
    host_write(BASE + 32'h4C, 32'hABCD_1919);
    host_write(BASE + 32'h0C, 32'h1234_0303);
    host_write(BASE + 32'h30, 32'hFFFF_1212);
    host_write(BASE + 32'h00, 32'h5555_0000);
    host_write(BASE + 32'h5C, 32'h0001_2323);
    repeat (10) @(negedge clk);
    chk(xfer_cnt == 0 && !tgt_wr_valid, "R3", "no transfer while down", 32'(xfer_cnt), 32'h0);
    expect_replay();
    subsys_up = 1'b1;
    drain();
    chk(xfer_cnt == 5, "R3", "held values forwarded", 32'(xfer_cnt), 32'd5);
    subsys_up = 1'b0;

    // R4: coalescing of rewrites
    base_cnt = xfer_cnt;
    host_write(BASE + 32'h14, 32'h0000_1111);
    host_write(BASE + 32'h44, 32'h0000_2222);
    host_write(BASE + 32'h14, 32'h0000_3333);
    host_write(BASE + 32'h44, 32'h0000_4444);
    host_write(BASE + 32'h44, 32'h0000_5555);
    expect_replay();
    ack_delay = 3;
    subsys_up = 1'b1;
    drain();
    chk(xfer_cnt - base_cnt == 2, "R4", "one transfer per entry", 32'(xfer_cnt - base_cnt), 32'd2);
    subsys_up = 1'b0;

    // R8: out-of-window and misaligned writes
    base_cnt = xfer_cnt;
    host_write(BASE - 32'd4, 32'h0000_AAAA);
    chk(addr_err, "R8", "err below window", 32'(addr_err), 32'h1);
    host_write(BASE + 32'd96, 32'h0000_BBBB);
    host_write(BASE + 32'd2, 32'h0000_CCCC);
    subsys_up = 1'b1;
    repeat (20) @(negedge clk);
    chk(xfer_cnt == base_cnt, "R8", "ignored writes forward nothing", 32'(xfer_cnt - base_cnt), 32'h0);
    chk(addr_err, "R8", "err sticky", 32'(addr_err), 32'h1);

    // R3 (power up): a write is forwarded directly
    ack_delay = 0;
    host_write(BASE + 32'h2C, 32'h9876_0B0B);
    expect_replay();
    drain();
    chk(exp_q.size() == 0, "R3", "write while up forwarded", 32'(exp_q.size()), 32'h0);
    subsys_up = 1'b0;

    // R6: rewrite of in-flight entry and a new lower entry
    host_write(BASE + 32'h08, 32'h0000_00A2);
    host_write(BASE + 32'h1C, 32'h0000_00B7);
    exp_q.push_back(mk(2, 16'h00A2));
    for (int i = 0; i < 24; i++) m_pend[i] = 1'b0;
    ack_delay = 20;
    subsys_up = 1'b1;
    while (!tgt_wr_valid) @(negedge clk);
    host_write(BASE + 32'h08, 32'h0000_00C2);
    host_write(BASE + 32'h04, 32'h0000_00D1);
    for (int i = 0; i < 24; i++) m_pend[i] = 1'b0;
    exp_q.push_back(mk(1, 16'h00D1));
    exp_q.push_back(mk(2, 16'h00C2));
    exp_q.push_back(mk(7, 16'h00B7));
    base_cnt = xfer_cnt;
    drain();
    chk(xfer_cnt - base_cnt == 4, "R6", "resend after in-flight rewrite", 32'(xfer_cnt - base_cnt), 32'd4);
    subsys_up = 1'b0;

    // R7: power drop during a transfer
    host_write(BASE + 32'h24, 32'h0000_0E09);
    for (int i = 0; i < 24; i++) m_pend[i] = 1'b0;
    ack_delay = 1000;
    base_cnt = xfer_cnt;
    subsys_up = 1'b1;
    while (!tgt_wr_valid) @(negedge clk);
    subsys_up = 1'b0;
    @(negedge clk);
    chk(!tgt_wr_valid, "R7", "valid dropped after power loss", 32'(tgt_wr_valid), 32'h0);
    repeat (5) @(negedge clk);
    chk(!tgt_wr_valid && xfer_cnt == base_cnt, "R7", "no transfer while down", 32'(xfer_cnt - base_cnt), 32'h0);
    ack_delay = 2;
    exp_q.push_back(mk(9, 16'h0E09));
    subsys_up = 1'b1;
    drain();
    chk(xfer_cnt - base_cnt == 1, "R7", "entry resent after power returns", 32'(xfer_cnt - base_cnt), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule